// File: doc/BRIEF.md
# Glitch-Free System Clock Prescaler with Guarded Divisor Changes

This block produces the clock enable for the system clock that feeds the CPU and every synchronous peripheral. The enable is a one-cycle pulse that comes once every 2^code cycles of the undivided input clock. An integrated clock gate outside the block uses it to build the divided clock. The counter runs on the undivided input clock, so the choice of clock source has no effect on the division.

Software changes the divisor through an 8-bit register port, and every change needs two writes. The first write is the unlock byte 0x80. The second carries the new code, and it must arrive within four input-clock cycles. Any other write pattern leaves the divisor as it is. An accepted code does not act at once. It waits for the end of the period that is running, so the pulse train never has a spacing shorter than the old or the new period.

Top module: `sysclk_prescaler`

## Requirements
- R1: After reset, ce_o is high in every cycle (divide by 1) and rd_data_o reads 0x00.
- R2: A write of exactly 0x80 (bit 7 set, all other bits clear) opens an unlock window. rd_data_o[7] reads 1 in the four cycles that start at the capturing edge, and reads 0 after that unless a new unlock opens it again.
- R3: A write with bit 7 clear, made while the window is open and with bits 3:0 at 8 or less, is accepted. Bits 6:4 are ignored. From the capturing edge, rd_data_o[3:0] shows the new code and rd_data_o[7] reads 0.
- R4: A code write captured on the fifth edge after the unlock edge, or on any later edge, is ignored. The readback and the pulse spacing stay as they were.
- R5: A code write made without an unlock before it is ignored. A write with bit 7 set and any other bit set is also ignored, and it closes an open window.
- R6: Codes 9 to 15 leave the divisor and the readback unchanged, and they close the window.
- R7: In steady state, ce_o is a single-cycle pulse that repeats every 2^code input cycles.
- R8: After a code is accepted, the first pulse seen on or after the capturing edge still ends an old-rate period. After that pulse, the pulses come at the new rate. No two pulses are closer together than the smaller of the old and new periods.
- R9: Let T1 be the old period and T2 the new period. The second pulse seen on or after the capturing edge of an accepted code comes between T2 and T1+T2-1 cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Undivided input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one byte per cycle |
| wr_data_i | input | 8 | Write data: bit 7 change enable, bits 3:0 division code |
| rd_data_o | output | 8 | Readback: bit 7 window open, bits 3:0 current code |
| ce_o | output | 1 | System clock enable pulse |

## Verification
If the divider counter or its limit holds a wrong value, ce_o shows it on the next pulse. That pulse comes a cycle early or late compared with the reference model, so the error is seen within one period of at most 256 cycles. A bad window count changes the readback of bit 7 in the same cycle, and it decides whether a select write a few cycles later is taken or rejected. A pending value that is lost or applied too early shows up as a wrong spacing around the switch-over. The bench catches this within two new-rate periods of the write.

// File: rtl/presc_pkg.sv
package presc_pkg;
    // register layout and limits shared by the prescaler and its checker
    localparam int DATA_W   = 8;   // register port width
    localparam int CE_BIT   = 7;   // change-enable / window-open bit position
    localparam int SEL_W    = 4;   // division code field, bits SEL_W-1:0
    localparam int MAX_CODE = 8;   // largest legal code, divide by 2**MAX_CODE
    localparam int WIN_CYC  = 4;   // unlock window length in input cycles

    localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;
    localparam int WIN_W = $clog2(WIN_CYC + 1);

    localparam logic [DATA_W-1:0] UNLOCK_PAT = DATA_W'(1) << CE_BIT;
endpackage

// File: rtl/presc_unlock.sv
module presc_unlock #(
    parameter int DATA_W   = presc_pkg::DATA_W,
    parameter int CE_BIT   = presc_pkg::CE_BIT,
    parameter int SEL_W    = presc_pkg::SEL_W,
    parameter int MAX_CODE = presc_pkg::MAX_CODE,
    parameter int WIN_CYC  = presc_pkg::WIN_CYC
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              acc_o,
    output logic [SEL_W-1:0]  acc_code_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              win_open_o
);
    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam logic [DATA_W-1:0] UNLOCK_PAT = DATA_W'(1) << CE_BIT;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [SEL_W-1:0] sel;
    } unl_st_t;

    unl_st_t          st_q, st_d;
    logic             open_w;
    logic             acc_d;
    logic [SEL_W-1:0] code_w;

    always_comb begin
        st_d   = st_q;
        acc_d  = 1'b0;
        code_w = wr_data_i[SEL_W-1:0];
        open_w = (st_q.win != '0);
        if (wr_en_i) begin
            if (wr_data_i == UNLOCK_PAT) begin
                st_d.win = WIN_W'(WIN_CYC);
            end else begin
                // every other write ends the window, taken or not
                st_d.win = '0;
                if (open_w && !wr_data_i[CE_BIT] && (code_w <= SEL_W'(MAX_CODE))) begin
                    acc_d    = 1'b1;
                    st_d.sel = code_w;
                end
            end
        end else if (open_w) begin
            st_d.win = st_q.win - WIN_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o      = acc_d;
    assign acc_code_o = code_w;
    assign sel_o      = st_q.sel;
    assign win_open_o = open_w;
endmodule

// File: rtl/presc_divider.sv
module presc_divider #(
    parameter int SEL_W    = presc_pkg::SEL_W,
    parameter int MAX_CODE = presc_pkg::MAX_CODE
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             acc_i,
    input  logic [SEL_W-1:0] acc_code_i,
    output logic             ce_o
);
    localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             pend;
        logic [CNT_W-1:0] pend_lim;
        logic             ce;
    } div_st_t;

    // terminal count for each legal code: 2**code - 1
    logic [CNT_W-1:0] lim_tab [MAX_CODE+1];
    for (genvar g = 0; g <= MAX_CODE; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'((64'd1 << g) - 64'd1);
    end

    div_st_t          st_q, st_d;
    logic [SEL_W-1:0] code_c;

    always_comb begin
        st_d   = st_q;
        code_c = (acc_code_i > SEL_W'(MAX_CODE)) ? '0 : acc_code_i;
        if (st_q.ce) begin
            // a period ends here: the only point where the limit may move
            st_d.cnt = '0;
            if (st_q.pend) begin
                st_d.lim  = st_q.pend_lim;
                st_d.pend = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (acc_i) begin
            st_d.pend     = 1'b1;
            st_d.pend_lim = lim_tab[code_c];
        end
        st_d.ce = (st_d.cnt == st_d.lim);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.ce  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ce_o = st_q.ce;
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler import presc_pkg::*; #(
    parameter int P_DATA_W   = DATA_W,
    parameter int P_CE_BIT   = CE_BIT,
    parameter int P_SEL_W    = SEL_W,
    parameter int P_MAX_CODE = MAX_CODE,
    parameter int P_WIN_CYC  = WIN_CYC
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [P_DATA_W-1:0] wr_data_i,
    output logic [P_DATA_W-1:0] rd_data_o,
    output logic                ce_o
);
    logic               acc;
    logic [P_SEL_W-1:0] acc_code;
    logic [P_SEL_W-1:0] sel;
    logic               win_open;

    presc_unlock #(
        .DATA_W   (P_DATA_W),
        .CE_BIT   (P_CE_BIT),
        .SEL_W    (P_SEL_W),
        .MAX_CODE (P_MAX_CODE),
        .WIN_CYC  (P_WIN_CYC)
    ) u_unlock (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .acc_o      (acc),
        .acc_code_o (acc_code),
        .sel_o      (sel),
        .win_open_o (win_open)
    );

    presc_divider #(
        .SEL_W    (P_SEL_W),
        .MAX_CODE (P_MAX_CODE)
    ) u_divider (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .acc_i      (acc),
        .acc_code_i (acc_code),
        .ce_o       (ce_o)
    );

    always_comb begin
        rd_data_o                = '0;
        rd_data_o[P_CE_BIT]      = win_open;
        rd_data_o[P_SEL_W-1:0]   = sel;
    end
endmodule

// File: rtl/presc_checker.sv
module presc_checker import presc_pkg::*; (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              ce_o
);
    localparam int GAP_W = MAX_CODE + 2;
    localparam int RUN_W = $clog2(WIN_CYC + 2) + 1;

    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] gap_len;
    logic [RUN_W-1:0] run_q;

    assign gap_len = gap_q + GAP_W'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q <= '0;
            run_q <= '0;
        end else begin
            gap_q <= ce_o ? '0 : ((gap_q == '1) ? gap_q : gap_q + GAP_W'(1));
            run_q <= (rd_data_o[CE_BIT] && !wr_en_i) ? run_q + RUN_W'(1) : '0;
        end
    end

    p_window_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= RUN_W'(WIN_CYC));

    p_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !rd_data_o[CE_BIT]) |=> $stable(rd_data_o[SEL_W-1:0]));

    p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(rd_data_o[SEL_W-1:0]));

    p_misuse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[CE_BIT] && wr_data_i != UNLOCK_PAT)
        |=> (!rd_data_o[CE_BIT] && $stable(rd_data_o[SEL_W-1:0])));

    p_reserved_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_data_i[CE_BIT] && wr_data_i[SEL_W-1:0] > SEL_W'(MAX_CODE))
        |=> (!rd_data_o[CE_BIT] && $stable(rd_data_o[SEL_W-1:0])));

    p_gap_pow2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_o |-> ($countones(gap_len) == 1));

    p_gap_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gap_len <= GAP_W'(64'd1 << MAX_CODE));
endmodule

bind sysclk_prescaler presc_checker u_presc_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .ce_o      (ce_o)
);

// File: tb/sysclk_prescaler_bench.sv
module sysclk_prescaler_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd;
    logic       ce;

    always #5 clk = ~clk;

    sysclk_prescaler u_sysclk_prescaler (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd),
        .ce_o      (ce)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: pulse timeline plus window countdown
    int       m_cyc = -1;
    int       m_next = -1;
    int       m_div = 1;
    int       m_pdiv = 1;
    int       m_rem = 0;
    bit       m_pend = 1'b0;
    bit       m_tick = 1'b1;
    bit [3:0] m_sel = 4'd0;
    int       ticks[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = -1; m_next = -1; m_div = 1; m_pdiv = 1;
            m_rem = 0; m_pend = 1'b0; m_tick = 1'b1; m_sel = 4'd0;
        end else begin
            m_cyc++;
            if (m_tick) begin
                if (m_pend) begin
                    m_div  = m_pdiv;
                    m_pend = 1'b0;
                end
                m_next = m_cyc - 1 + m_div;
            end
            if (wr_en) begin
                if (wr_data == 8'h80) begin
                    m_rem = 4;
                end else begin
                    if (m_rem > 0 && !wr_data[7] && wr_data[3:0] <= 4'd8) begin
                        m_sel  = wr_data[3:0];
                        m_pend = 1'b1;
                        m_pdiv = 1 << wr_data[3:0];
                    end
                    m_rem = 0;
                end
            end else if (m_rem > 0) begin
                m_rem--;
            end
            m_tick = (m_cyc == m_next);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(ce === m_tick, "R8 per-cycle ce_o vs model", int'(ce), int'(m_tick));
            check(rd === {(m_rem != 0), 3'b000, m_sel}, "R2/R3 per-cycle readback",
                  int'(rd), int'({(m_rem != 0), 3'b000, m_sel}));
            if (ce === 1'b1) ticks.push_back(m_cyc);
        end
    end

    task automatic wr(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // unlock, write a code, then measure the spacing around the switch
    task automatic sw(input int code, input int old);
        int k, nw, lastold, t1, t2, t3, found;
        nw = 1 << code;
        k  = m_cyc + 2;
        wr(8'h80);
        wr(8'(code));
        check(rd[3:0] == 4'(code), "R3 code readback", int'(rd[3:0]), code);
        idle(old + 2 * nw + 4);
        lastold = -1; t1 = -1; t2 = -1; t3 = -1; found = 0;
        foreach (ticks[i]) begin
            if (ticks[i] < k) lastold = ticks[i];
            else if (found == 0) begin t1 = ticks[i]; found = 1; end
            else if (found == 1) begin t2 = ticks[i]; found = 2; end
            else if (found == 2) begin t3 = ticks[i]; found = 3; end
        end
        check(found == 3, "R8 three pulses after switch", found, 3);
        if (lastold >= 0)
            check(t1 - lastold >= ((old < nw) ? old : nw), "R8 min spacing first gap",
                  t1 - lastold, (old < nw) ? old : nw);
        check(t2 - t1 == nw, "R8 first new-rate gap", t2 - t1, nw);
        check(t2 - k >= nw && t2 - k <= old + nw - 1, "R9 latency window", t2 - k, nw);
        check(t3 - t2 == nw, "R7 steady period", t3 - t2, nw);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired R7 actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int old;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ce == 1'b1, "R1 ce after reset", int'(ce), 1);
        check(rd == 8'h00, "R1 readback after reset", int'(rd), 0);
        idle(1);
        check(ce == 1'b1, "R1 divide by one", int'(ce), 1);

        // R2: window lasts four cycles
        wr(8'h80);
        for (int i = 0; i < 4; i++) begin
            check(rd[7] == 1'b1, "R2 window open", int'(rd[7]), 1);
            idle(1);
        end
        check(rd[7] == 1'b0, "R2 window expired", int'(rd[7]), 0);

        // R3: accepted code, upper bits ignored
        wr(8'h80);
        wr(8'h72);
        check(rd == 8'h02, "R3 accepted with bits 6:4 ignored", int'(rd), 2);

        // R4: late write rejected, last window cycle accepted
        wr(8'h80);
        idle(4);
        wr(8'h01);
        check(rd[3:0] == 4'd2, "R4 late write ignored", int'(rd[3:0]), 2);
        wr(8'h80);
        idle(3);
        wr(8'h01);
        check(rd[3:0] == 4'd1, "R3 last window cycle accepted", int'(rd[3:0]), 1);

        // R5: no unlock, and bit 7 combined with a code
        wr(8'h03);
        check(rd[3:0] == 4'd1, "R5 write without unlock ignored", int'(rd[3:0]), 1);
        wr(8'h80);
        wr(8'h83);
        check(rd == 8'h01, "R5 combined write ignored and closes", int'(rd), 1);
        wr(8'h03);
        check(rd[3:0] == 4'd1, "R5 window stays closed", int'(rd[3:0]), 1);

        // R6: reserved codes
        wr(8'h80);
        wr(8'h09);
        check(rd == 8'h01, "R6 code 9 ignored", int'(rd), 1);
        wr(8'h80);
        wr(8'h0F);
        check(rd == 8'h01, "R6 code 15 ignored", int'(rd), 1);
        idle(8);

        // R7 R8 R9: sweep every code, then random changes
        old = 2;
        for (int c = 0; c <= 8; c++) begin
            sw(c, old);
            old = 1 << c;
        end
        for (int c = 8; c >= 0; c--) begin
            sw(c, old);
            old = 1 << c;
        end
        for (int n = 0; n < 30; n++) begin
            int c;
            c = $urandom_range(8, 0);
            sw(c, old);
            old = 1 << c;
        end

        // random write traffic against the cycle model
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(9, 0);
            if (r < 2) wr(8'h80);
            else if (r < 4) wr(8'($urandom_range(15, 0)));
            else if (r == 4) wr(8'($urandom_range(255, 0)));
            else idle(1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule